// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Flags

This block is the 8-bit arithmetic core that sits next to an accumulator and a five-bit flag register. On each clock edge where the load strobe is high, it takes an operation code and one 8-bit operand and computes a new value. Depending on the operation, it either writes that value back into the accumulator or reports it as the new value of the operand. The operand's origin (register, memory or immediate byte) is decided elsewhere and does not matter here.

Every operation goes through one shared adder. Subtraction adds the inverted operand with a carry-in, so the stored carry flag means "borrow" after any subtract-type operation. Increment and decrement act on the operand alone. They refresh sign, zero, auxiliary carry and parity, and they leave carry exactly as it was. Compare runs the subtract path, updates the flags and leaves the accumulator alone.

Top module: `acc_alu_top`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the flag register and the result register to zero.
- R2: While the load strobe is low, the accumulator, flags and result do not change, whatever the operation code and operand are.
- R3: Code 0 (add) stores (A+B) mod 256 in the accumulator and sets carry to bit 8 of A+B.
- R4: Code 1 (add with carry) stores (A+B+CY) mod 256 in the accumulator and sets carry to bit 8 of A+B+CY.
- R5: Code 2 (subtract) stores (A-B) mod 256 in the accumulator and sets carry to 1 exactly when B is greater than A.
- R6: Code 3 (subtract with borrow) stores (A-B-CY) mod 256 in the accumulator and sets carry to 1 exactly when B+CY is greater than A.
- R7: Code 4 (compare) produces the same flags and result as code 2 but leaves the accumulator unchanged.
- R8: Code 5 (increment) and code 6 (decrement) put (B+1) mod 256 or (B-1) mod 256 in the result register, leave the accumulator unchanged, keep carry at its old value and update the other four flags.
- R9: The flag port is {sign, zero, aux, parity, carry} from bit 4 down to bit 0. Sign equals result bit 7, zero is set when the 8-bit result is 0, and parity is set when the result has an even number of 1 bits.
- R10: Aux (bit 2) is the carry out of bit 3 of the adder. For additions, it is set when the low nibbles plus the carry-in exceed 15. For subtract-type operations, it is set when no borrow out of the low nibble occurs (low nibble of A is at least low nibble of B plus borrow-in). For increment, it is set when the operand's low nibble is 15. For decrement, it is set when that low nibble is non-zero.
- R11: Code 7 is reserved. With the load strobe high, it changes no register.
- R12: The result port shows the 8-bit result of the most recent accepted operation (codes 0 to 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Strobe that accepts the operation on this edge |
| op_i | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 increment, 6 decrement, 7 reserved) |
| operand_i | input | 8 | Second operand (B) |
| acc_o | output | 8 | Accumulator (A) |
| result_o | output | 8 | Result of the last accepted operation |
| flags_o | output | 5 | {sign, zero, aux, parity, carry} |

## Verification
Every operation code is driven with every operand value, against accumulators chosen at the nibble and sign boundaries (0x00, 0x0F, 0x7F, 0x80, 0xF7, 0xFF). Each combination is run with carry both clear and set.

These sweeps separate specific outcomes:
- carry-out from borrow at both ends of the range;
- aux from low-nibble carry and low-nibble borrow;
- a carry-in that is used from one that is ignored, which splits add from add-with-carry, subtract from subtract-with-borrow, and increment/decrement from the operations that write carry.

Further short sequences cover a low load strobe, a reset in mid-state and the reserved code, which show that the registers hold.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W   = 8;
    localparam int NIB_W    = 4;
    localparam int NUM_NIBS = DATA_W / NIB_W;
    localparam int OP_W     = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_CMP = 3'd4,
        OP_INC = 3'd5,
        OP_DEC = 3'd6,
        OP_RSV = 3'd7
    } alu_op_e;

    // bit order matters: it is the flag port layout
    typedef struct packed {
        logic sign;
        logic zero;
        logic aux;
        logic parity;
        logic carry;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              cin;
        logic              is_sub;
        logic              keep_cy;
        logic              wr_acc;
        logic              valid;
    } alu_ctrl_t;

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic              c_out;
        logic              c_aux;
    } adder_out_t;

    function automatic logic even_parity(input logic [DATA_W-1:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] acc,
    input  logic              cy,
    input  logic [DATA_W-1:0] operand,
    output alu_ctrl_t         ctrl
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    always_comb begin
        ctrl         = '0;
        ctrl.a       = acc;
        ctrl.b       = operand;
        ctrl.valid   = 1'b1;
        unique case (alu_op_e'(op))
            OP_ADD: ctrl.wr_acc = 1'b1;
            OP_ADC: begin
                ctrl.cin    = cy;
                ctrl.wr_acc = 1'b1;
            end
            OP_SUB: begin
                ctrl.b      = ~operand;
                ctrl.cin    = 1'b1;
                ctrl.is_sub = 1'b1;
                ctrl.wr_acc = 1'b1;
            end
            OP_SBB: begin
                ctrl.b      = ~operand;
                ctrl.cin    = ~cy;
                ctrl.is_sub = 1'b1;
                ctrl.wr_acc = 1'b1;
            end
            OP_CMP: begin
                ctrl.b      = ~operand;
                ctrl.cin    = 1'b1;
                ctrl.is_sub = 1'b1;
            end
            OP_INC: begin
                ctrl.a       = operand;
                ctrl.b       = ONE;
                ctrl.keep_cy = 1'b1;
            end
            OP_DEC: begin
                ctrl.a       = operand;
                ctrl.b       = ~ONE;
                ctrl.cin     = 1'b1;
                ctrl.is_sub  = 1'b1;
                ctrl.keep_cy = 1'b1;
            end
            default: ctrl.valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_alu_adder.sv
module acc_alu_adder
    import acc_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output adder_out_t        res
);

    logic [NUM_NIBS:0]   carry;
    logic [DATA_W-1:0]   sum;

    assign carry[0] = cin;

    for (genvar g = 0; g < NUM_NIBS; g++) begin : g_nib
        logic [NIB_W:0] part;
        assign part = {1'b0, a[g*NIB_W +: NIB_W]}
                    + {1'b0, b[g*NIB_W +: NIB_W]}
                    + {{NIB_W{1'b0}}, carry[g]};
        assign sum[g*NIB_W +: NIB_W] = part[NIB_W-1:0];
        assign carry[g+1]            = part[NIB_W];
    end

    assign res.sum   = sum;
    assign res.c_out = carry[NUM_NIBS];
    assign res.c_aux = carry[1];

endmodule

// File: rtl/acc_alu_flaggen.sv
module acc_alu_flaggen
    import acc_alu_pkg::*;
(
    input  adder_out_t add,
    input  logic       is_sub,
    input  logic       keep_cy,
    input  logic       old_cy,
    output flags_t     flags
);

    always_comb begin
        flags.sign   = add.sum[DATA_W-1];
        flags.zero   = (add.sum == '0);
        flags.aux    = add.c_aux;
        flags.parity = even_parity(add.sum);
        if (keep_cy)
            flags.carry = old_cy;
        else
            flags.carry = is_sub ? ~add.c_out : add.c_out;
    end

endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o
);

    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] res_q;
    flags_t            flags_q;
    alu_ctrl_t         ctrl;
    adder_out_t        add;
    flags_t            flags_nx;

    acc_alu_opsel u_opsel (
        .op      (op_i),
        .acc     (acc_q),
        .cy      (flags_q.carry),
        .operand (operand_i),
        .ctrl    (ctrl)
    );

    acc_alu_adder u_adder (
        .a   (ctrl.a),
        .b   (ctrl.b),
        .cin (ctrl.cin),
        .res (add)
    );

    acc_alu_flaggen u_flaggen (
        .add     (add),
        .is_sub  (ctrl.is_sub),
        .keep_cy (ctrl.keep_cy),
        .old_cy  (flags_q.carry),
        .flags   (flags_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            res_q   <= '0;
            flags_q <= '0;
        end else if (load_i && ctrl.valid) begin
            res_q   <= add.sum;
            flags_q <= flags_nx;
            if (ctrl.wr_acc)
                acc_q <= add.sum;
        end
    end

    assign acc_o    = acc_q;
    assign result_o = res_q;
    assign flags_o  = flags_q;

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(acc_q) && $stable(res_q) && $stable(flags_q)));

    assert_cmp_keeps_acc_R7: assert property (@(posedge clk) disable iff (rst)
        (load_i && op_i == OP_CMP) |=> $stable(acc_q));

    assert_incdec_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (load_i && (op_i == OP_INC || op_i == OP_DEC))
        |=> (flags_q.carry == $past(flags_q.carry)) && $stable(acc_q));

    assert_zero_sign_R9: assert property (@(posedge clk) disable iff (rst)
        (load_i && op_i != OP_RSV)
        |=> (flags_q.zero == (res_q == '0)) && (flags_q.sign == res_q[DATA_W-1]));

    assert_reserved_R11: assert property (@(posedge clk) disable iff (rst)
        (load_i && op_i == OP_RSV)
        |=> ($stable(acc_q) && $stable(res_q) && $stable(flags_q)));

    assert_add_writes_acc_R12: assert property (@(posedge clk) disable iff (rst)
        (load_i && op_i <= OP_SBB) |=> (acc_q == res_q));

endmodule

// File: tb/acc_alu_top_bench.sv
module acc_alu_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic [2:0] op_i = '0;
    logic [7:0] operand_i = '0;
    logic [7:0] acc_o;
    logic [7:0] result_o;
    logic [4:0] flags_o;

    int checks = 0;
    int fails  = 0;

    // bench model
    int       m_acc = 0;
    int       m_res = 0;
    bit [4:0] m_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu_top u_acc_alu_top (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .op_i      (op_i),
        .operand_i (operand_i),
        .acc_o     (acc_o),
        .result_o  (result_o),
        .flags_o   (flags_o)
    );

    function automatic string op_tag(int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5, 6: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_acc = 0; m_res = 0; m_flags = '0;
    endtask

    task automatic model_apply(int op, int b);
        int a = m_acc;
        int c = m_flags[0];
        int r = 0;
        bit cy = m_flags[0];
        bit ac = 1'b0;
        bit [7:0] rb;
        case (op)
            0: begin r = a + b;     cy = (r > 255); ac = ((a % 16) + (b % 16)) > 15; end
            1: begin r = a + b + c; cy = (r > 255); ac = ((a % 16) + (b % 16) + c) > 15; end
            2, 4: begin r = a - b;  cy = (r < 0);   ac = ((a % 16) - (b % 16)) >= 0; end
            3: begin r = a - b - c; cy = (r < 0);   ac = ((a % 16) - (b % 16) - c) >= 0; end
            5: begin r = b + 1; ac = ((b % 16) == 15); end
            6: begin r = b - 1; ac = ((b % 16) != 0); end
            default: return;
        endcase
        rb    = 8'(r);
        m_res = int'(rb);
        if (op <= 3) m_acc = m_res;
        m_flags = {rb[7], (rb == 8'd0), ac, ~^rb, cy};
    endtask

    // drive at a falling edge, result is registered at the rising edge,
    // sampled at the next falling edge
    task automatic do_op(int op, int b, bit verify);
        load_i    = 1'b1;
        op_i      = 3'(op);
        operand_i = 8'(b);
        @(negedge clk);
        load_i = 1'b0;
        model_apply(op, b);
        if (verify) begin
            check({op_tag(op), " R12 acc/result"}, {acc_o, result_o}, {m_acc[7:0], m_res[7:0]});
            check({op_tag(op), " R9 R10 flags"}, int'(flags_o), int'(m_flags));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic set_state(int x, bit c);
        do_reset();
        if (!c) do_op(0, x, 1'b0);
        else if (x == 255) do_op(2, 1, 1'b0);
        else begin
            do_op(0, 255, 1'b0);
            do_op(0, (x + 1) % 256, 1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int avals[6] = '{8'h00, 8'h0F, 8'h7F, 8'h80, 8'hF7, 8'hFF};
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 reset acc", acc_o, 0);
        check("R1 reset result", result_o, 0);
        check("R1 reset flags", flags_o, 0);

        // R2: load low holds state
        set_state(8'h3C, 1'b1);
        load_i = 1'b0; op_i = 3'd0; operand_i = 8'h55;
        @(negedge clk);
        op_i = 3'd5;
        @(negedge clk);
        check("R2 hold acc/result", {acc_o, result_o}, {m_acc[7:0], m_res[7:0]});
        check("R2 hold flags", flags_o, m_flags);

        // R11: reserved code ignored
        do_op(7, 8'h12, 1'b1);
        check("R11 reserved acc", acc_o, 8'h3C);

        // R8: increment wrap keeps carry set, decrement from zero keeps it
        do_op(5, 8'hFF, 1'b1);
        check("R8 inc wrap carry kept", flags_o[0], 1);
        check("R8 inc acc unchanged", acc_o, 8'h3C);
        do_op(6, 8'h00, 1'b1);
        check("R8 dec result", result_o, 8'hFF);

        // R7: compare keeps accumulator
        do_op(4, 8'h3C, 1'b1);
        check("R7 cmp equal zero flag", flags_o[3], 1);
        check("R7 cmp acc", acc_o, 8'h3C);

        // R1: reset in mid-state
        do_reset();
        check("R1 mid reset", {acc_o, result_o, 3'b000, flags_o}, 0);

        // sweep
        for (int op = 0; op < 8; op++)
            for (int ai = 0; ai < 6; ai++)
                for (int c = 0; c < 2; c++)
                    for (int b = 0; b < 256; b++) begin
                        set_state(avals[ai], c[0]);
                        do_op(op, b, 1'b1);
                    end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule